// File: doc/BRIEF.md
# Exception entry and return sequencer

This block carries out the register side effects of taking a processor exception and of returning from one. Each cycle it looks at seven exception requests, together with the core's current program counter and status word. It picks the single most urgent request that is not masked. One cycle later it presents the new program counter (the vector for that exception) and the new status word. In the same cycle it pulses write strobes that save the old status word and the return address into the bank that belongs to the target mode.

The block keeps a small model of the banked saved-status and link registers for the five exception modes. It uses this model to serve a return request. A return reloads the status word from the current mode's saved copy and the program counter from that mode's link register. The surrounding core is expected to adopt `pc_out` and `psr_out` whenever `upd` is high.

Top module: `exc_seq`

## Requirements
- R1: After `rst_n` is released and before any request, `upd`, `lr_we` and `spsr_we` are 0, `pc_out` is 0 and `psr_out` is 0x000000D3. That value is Supervisor mode 0x13 in bits 4:0, with I (bit 7) and F (bit 6) set.
- R2: An exception taken in cycle n gives `upd`=1 and `pc_out` equal to its vector in cycle n+1. The vectors are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R3: The mode field of `psr_out` and `bank_mode` hold the target mode. Software interrupt and reset go to Supervisor 0x13. Both aborts go to Abort 0x17. Undefined goes to 0x1B, IRQ to 0x12 and FIQ to 0x11.
- R4: For any exception other than reset, `psr_out` copies `psr_in`, with these changes: T (bit 5) and J (bit 24) are cleared and I is set. F is set for FIQ and kept otherwise. Bits 31:28 and 27 are kept unchanged.
- R5: On entry, `lr_we` and `spsr_we` pulse together with `upd`. `lr_wdata` carries the `pc_in` of the request cycle and `spsr_wdata` carries the `psr_in` of the request cycle.
- R6: An IRQ request while `psr_in` bit 7 is set has no effect, and neither does an FIQ request while bit 6 is set. In both cases `upd` stays 0.
- R7: Among requests in the same cycle only one is taken. The order is reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt; a return is taken only when none of these is.
- R8: A return request in an exception mode gives `upd`=1 one cycle later, with no bank strobes. `psr_out` and `pc_out` then hold the status word and return address last saved into that mode's bank.
- R9: A return request while the mode field is User 0x10 or System 0x1F has no effect: `upd` stays 0.
- R10: A reset request gives `pc_out`=0 and `psr_out`=0x000000D3, whatever the previous status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rst | input | 1 | Reset exception request |
| req_und | input | 1 | Undefined-instruction request |
| req_swi | input | 1 | Software-interrupt request |
| req_pabt | input | 1 | Prefetch-abort request |
| req_dabt | input | 1 | Data-abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| req_ret | input | 1 | Exception return request |
| pc_in | input | 32 | Current program counter / return address |
| psr_in | input | 32 | Current status word |
| upd | output | 1 | New PC and status word valid this cycle |
| pc_out | output | 32 | New program counter |
| psr_out | output | 32 | New status word |
| lr_we | output | 1 | Link register write strobe |
| spsr_we | output | 1 | Saved status register write strobe |
| bank_mode | output | 5 | Mode whose bank is written |
| lr_wdata | output | 32 | Return address written to the bank |
| spsr_wdata | output | 32 | Status word written to the bank |

## Verification
A wrong priority choice or mode mapping shows at the ports one cycle after the request, as a wrong vector in `pc_out` or a wrong mode field in `psr_out`. A corrupted or misdirected bank entry stays hidden at entry time. It only appears when that mode later returns, as a wrong restored status word or address. For that reason the bench nests one exception inside another and returns from both. A mask that is ignored shows as an unexpected `upd` pulse in the cycle after the masked request.

// File: rtl/exc_seq.sv
module exc_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_rst,
  input  logic        req_und,
  input  logic        req_swi,
  input  logic        req_pabt,
  input  logic        req_dabt,
  input  logic        req_irq,
  input  logic        req_fiq,
  input  logic        req_ret,
  input  logic [31:0] pc_in,
  input  logic [31:0] psr_in,
  output logic        upd,
  output logic [31:0] pc_out,
  output logic [31:0] psr_out,
  output logic        lr_we,
  output logic        spsr_we,
  output logic [4:0]  bank_mode,
  output logic [31:0] lr_wdata,
  output logic [31:0] spsr_wdata
);
  localparam logic [4:0]  M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
                          M_ABT = 5'h17, M_UND = 5'h1B;
  localparam int          NBANK = 5;
  localparam int          BW = $clog2(NBANK + 1);
  localparam logic [BW-1:0] NOBANK = BW'(NBANK);
  localparam logic [31:0] RST_PSR = {24'h0, 3'b110, M_SVC};

  logic [31:0] spsr_q [NBANK];
  logic [31:0] lr_q   [NBANK];

  function automatic logic [BW-1:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return BW'(0);
      M_IRQ:   return BW'(1);
      M_SVC:   return BW'(2);
      M_ABT:   return BW'(3);
      M_UND:   return BW'(4);
      default: return NOBANK;
    endcase
  endfunction

  logic            take, set_f, ret_ok;
  logic [4:0]      tgt;
  logic [31:0]     vec, new_psr;
  logic [BW-1:0]   cur_bank, tgt_bank;

  assign cur_bank = bank_of(psr_in[4:0]);
  assign tgt_bank = bank_of(tgt);

  always_comb begin
    take = 1'b1; set_f = 1'b0; tgt = M_SVC; vec = 32'h00;
    if (req_rst)                       begin set_f = 1'b1; end
    else if (req_dabt)                 begin tgt = M_ABT; vec = 32'h10; end
    else if (req_fiq && !psr_in[6])    begin tgt = M_FIQ; vec = 32'h1C; set_f = 1'b1; end
    else if (req_irq && !psr_in[7])    begin tgt = M_IRQ; vec = 32'h18; end
    else if (req_pabt)                 begin tgt = M_ABT; vec = 32'h0C; end
    else if (req_und)                  begin tgt = M_UND; vec = 32'h04; end
    else if (req_swi)                  begin vec = 32'h08; end
    else                               take = 1'b0;
  end

  assign ret_ok  = !take && req_ret && (cur_bank != NOBANK);
  assign new_psr = req_rst ? RST_PSR :
                   {psr_in[31:25], 1'b0, psr_in[23:8], 1'b1, psr_in[6] | set_f, 1'b0, tgt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd        <= 1'b0;
      lr_we      <= 1'b0;
      spsr_we    <= 1'b0;
      pc_out     <= 32'h0;
      psr_out    <= RST_PSR;
      bank_mode  <= M_SVC;
      lr_wdata   <= 32'h0;
      spsr_wdata <= 32'h0;
      for (int i = 0; i < NBANK; i++) begin
        spsr_q[i] <= 32'h0;
        lr_q[i]   <= 32'h0;
      end
    end else begin
      upd     <= take | ret_ok;
      lr_we   <= take;
      spsr_we <= take;
      if (take) begin
        pc_out           <= vec;
        psr_out          <= new_psr;
        bank_mode        <= tgt;
        lr_wdata         <= pc_in;
        spsr_wdata       <= psr_in;
        spsr_q[tgt_bank] <= psr_in;
        lr_q[tgt_bank]   <= pc_in;
      end else if (ret_ok) begin
        pc_out  <= lr_q[cur_bank];
        psr_out <= spsr_q[cur_bank];
      end
    end
  end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_rst,
  input logic        req_und,
  input logic        req_swi,
  input logic        req_pabt,
  input logic        req_dabt,
  input logic        req_irq,
  input logic        req_fiq,
  input logic        req_ret,
  input logic [31:0] pc_in,
  input logic [31:0] psr_in,
  input logic        upd,
  input logic [31:0] pc_out,
  input logic [31:0] psr_out,
  input logic        lr_we,
  input logic        spsr_we,
  input logic [4:0]  bank_mode,
  input logic [31:0] lr_wdata,
  input logic [31:0] spsr_wdata
);
  logic others_idle;
  assign others_idle = !req_rst && !req_dabt && !req_pabt && !req_und && !req_swi && !req_ret;

  a_r5_strobes_paired: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> (spsr_we && upd));
  a_r5_saved_values: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ret || req_ret) ##1 lr_we |-> (spsr_wdata == $past(psr_in) && lr_wdata == $past(pc_in)));
  a_r4_arm_state: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> (!psr_out[5] && !psr_out[24] && psr_out[7]));
  a_r3_mode_matches_bank: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> psr_out[4:0] == bank_mode);
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_irq && psr_in[7] && !req_fiq && others_idle) |=> !upd);
  a_r6_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fiq && psr_in[6] && !req_irq && others_idle) |=> !upd);
  a_r10_reset_forces: assert property (@(posedge clk) disable iff (!rst_n)
    req_rst |=> (upd && pc_out == 32'h0 && psr_out == 32'h000000D3));
  a_r2_vector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> (pc_out[1:0] == 2'b00 && pc_out != 32'h14 && pc_out <= 32'h1C));
endmodule

bind exc_seq exc_seq_chk u_chk (.*);

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_rst, req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq, req_ret;
  logic [31:0] pc_in, psr_in, pc_out, psr_out, lr_wdata, spsr_wdata;
  logic upd, lr_we, spsr_we;
  logic [4:0] bank_mode;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  exc_seq u_exc_seq (.*);

  // request index: 0 rst, 1 dabt, 2 fiq, 3 irq, 4 pabt, 5 und, 6 swi
  function automatic logic [31:0] vec_of(int k);
    case (k) 0: return 32'h00; 1: return 32'h10; 2: return 32'h1C; 3: return 32'h18;
             4: return 32'h0C; 5: return 32'h04; default: return 32'h08; endcase
  endfunction
  function automatic logic [4:0] mode_of(int k);
    case (k) 0: return 5'h13; 1: return 5'h17; 2: return 5'h11; 3: return 5'h12;
             4: return 5'h17; 5: return 5'h1B; default: return 5'h13; endcase
  endfunction
  function automatic logic [31:0] entry_psr(logic [31:0] old, int k);
    logic [31:0] p;
    if (k == 0) return 32'h000000D3;
    p = old; p[24] = 1'b0; p[5] = 1'b0; p[7] = 1'b1;
    if (k == 2) p[6] = 1'b1;
    p[4:0] = mode_of(k);
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] r, input logic ret);
    @(negedge clk);
    {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst} = r;
    req_ret = ret;
    @(negedge clk);
    {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst} = '0;
    req_ret = 1'b0;
  endtask

  task automatic commit;
    pc_in = pc_out; psr_in = psr_out;
  endtask

  task automatic enter_and_check(input int k, input logic [31:0] pc0, input logic [31:0] psr0);
    logic [31:0] ep;
    pc_in = pc0; psr_in = psr0;
    ep = entry_psr(psr0, k);
    drive(7'(1 << k), 1'b0);
    chk(upd == 1'b1, $sformatf("R2 upd type%0d", k), 32'(upd), 1);
    chk(pc_out == vec_of(k), $sformatf("R2 vector type%0d", k), pc_out, vec_of(k));
    chk(psr_out[4:0] == mode_of(k) && bank_mode == mode_of(k), $sformatf("R3 mode type%0d", k),
        32'(psr_out[4:0]), 32'(mode_of(k)));
    if (k == 0) chk(psr_out == 32'hD3, "R10 reset psr", psr_out, 32'hD3);
    else chk(psr_out == ep, $sformatf("R4 psr type%0d", k), psr_out, ep);
    chk(lr_we && spsr_we && lr_wdata == pc0 && spsr_wdata == psr0,
        $sformatf("R5 bank write type%0d", k), lr_wdata, pc0);
  endtask

  task automatic t_reset_state;
    chk(!upd && !lr_we && !spsr_we, "R1 strobes idle", 32'({upd, lr_we, spsr_we}), 0);
    chk(pc_out == 0, "R1 pc", pc_out, 0);
    chk(psr_out == 32'hD3, "R1 psr", psr_out, 32'hD3);
  endtask

  task automatic t_all_types;
    for (int k = 0; k < 7; k++)
      enter_and_check(k, 32'h1000 + 32'(k * 4), 32'hF100_0030 | 32'h10);
    // masks open, F kept clear for non-FIQ, flags vary
    enter_and_check(3, 32'h2000, 32'h5000_0010);
    enter_and_check(6, 32'h2004, 32'h0000_0050);
  endtask

  task automatic t_masked;
    pc_in = 32'h300; psr_in = 32'h0000_0090;
    drive(7'b0001000, 1'b0);
    chk(!upd, "R6 irq masked by I", 32'(upd), 0);
    psr_in = 32'h0000_0050;
    drive(7'b0000100, 1'b0);
    chk(!upd, "R6 fiq masked by F", 32'(upd), 0);
    drive(7'b0001000, 1'b0);
    chk(upd && pc_out == 32'h18, "R6 irq taken with I clear", pc_out, 32'h18);
  endtask

  task automatic t_priority;
    pc_in = 32'h400; psr_in = 32'h10;
    drive(7'b1111111, 1'b1);
    chk(pc_out == 32'h00, "R7 reset wins", pc_out, 0);
    drive(7'b1111110, 1'b1);
    chk(pc_out == 32'h10, "R7 data abort wins", pc_out, 32'h10);
    drive(7'b1111100, 1'b1);
    chk(pc_out == 32'h1C, "R7 fiq wins", pc_out, 32'h1C);
    drive(7'b1111000, 1'b1);
    chk(pc_out == 32'h18, "R7 irq wins", pc_out, 32'h18);
    drive(7'b1110000, 1'b1);
    chk(pc_out == 32'h0C, "R7 prefetch abort wins", pc_out, 32'h0C);
    drive(7'b1100000, 1'b1);
    chk(pc_out == 32'h04, "R7 undefined wins", pc_out, 32'h04);
    psr_in = 32'h40;
    drive(7'b1000100, 1'b0);
    chk(pc_out == 32'h08, "R7 masked fiq loses to swi", pc_out, 32'h08);
  endtask

  task automatic t_nested_return;
    logic [31:0] usr_psr, irq_psr, irq_pc;
    usr_psr = 32'hA000_0010;
    pc_in = 32'h8000; psr_in = usr_psr;
    drive(7'b0001000, 1'b0); commit;
    irq_psr = psr_in; irq_pc = 32'h8100; pc_in = irq_pc;
    drive(7'b0000100, 1'b0); commit;
    chk(psr_in[4:0] == 5'h11, "R3 nested fiq mode", 32'(psr_in[4:0]), 32'h11);
    drive(7'b0000000, 1'b1);
    chk(upd && !lr_we && !spsr_we, "R8 return strobes", 32'({upd, lr_we, spsr_we}), 32'b100);
    chk(psr_out == irq_psr && pc_out == irq_pc, "R8 fiq return restores irq", psr_out, irq_psr);
    commit;
    drive(7'b0000000, 1'b1);
    chk(psr_out == usr_psr && pc_out == 32'h8000, "R8 irq return restores user", pc_out, 32'h8000);
    commit;
    drive(7'b0000000, 1'b1);
    chk(!upd, "R9 return in user ignored", 32'(upd), 0);
    psr_in = 32'h1F;
    drive(7'b0000000, 1'b1);
    chk(!upd, "R9 return in system ignored", 32'(upd), 0);
  endtask

  task automatic t_reset_exception;
    pc_in = 32'hDEAD_BEE0; psr_in = 32'hFFFF_FF37;
    drive(7'b0000001, 1'b0);
    chk(psr_out == 32'hD3 && pc_out == 0, "R10 reset from arbitrary state", psr_out, 32'hD3);
  endtask

  initial begin
    {req_rst, req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq, req_ret} = '0;
    pc_in = '0; psr_in = 32'h10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state;
    t_all_types;
    t_masked;
    t_priority;
    t_nested_return;
    t_reset_exception;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule